// File: doc/BRIEF.md
# UART Receive Holding Register

This block is the last stage of an asynchronous serial receiver. A small oversampling shifter turns the serial line into data bits. When the shifter finishes a frame, the holding stage may copy the bits into a byte-wide register that a host reads. Each copy also gives a single-cycle interrupt pulse.

Three things decide whether a finished frame is copied. Receive enable must be high. The previous byte must have been read, because an unread byte turns the new frame into an overrun and the new frame is dropped. A unit enable at 0 forces the register to all ones, holds the shifter idle and forgets any pending read. A length select chooses frames of seven or eight data bits.

Each clock cycle counts as one oversampling tick, so a bit lasts `OVS` clocks.

Top module: `uart_rx_hold`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `rx_data` is 8'hFF and `rx_done_irq` is 0.
- R2: One clock after `unit_en` is sampled low, `rx_data` is 8'hFF and `rx_done_irq` is 0. Frames sent while `unit_en` is low produce no load and no interrupt.
- R3: A frame is a low start bit, then data bits LSB first, then a high stop bit, each `OVS` clocks long. With `len7`=0 there are 8 data bits, and `rx_data` takes all 8 of them at the middle of the stop bit.
- R4: Each load produces exactly one `rx_done_irq` pulse, one clock wide. It is high in the same cycle that the new value first appears on `rx_data`. `rx_data` never moves to a value other than 8'hFF without this pulse.
- R5: With `rx_en`=0 when a frame completes, `rx_data` keeps its value and no interrupt is raised.
- R6: With `len7`=1 a frame carries 7 data bits. `rx_data[6:0]` takes them and `rx_data[7]` is 0.
- R7: A frame that completes while a read is still pending is an overrun. It is not loaded and raises no interrupt. A read is pending from a load until a `host_rd` pulse.
- R8: A `host_rd` pulse after a load clears the pending read, so that the next frame loads.
- R9: A low pulse on `rxd` that ends before half a bit period is not taken as a start bit. It produces no frame, and the shifter stays ready for the next frame.
- R10: Taking `unit_en` low clears the pending read, so that after re-enabling, a frame loads without a prior `host_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one oversampling tick per cycle |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| unit_en | input | 1 | Unit enable; 0 forces idle and all-ones output |
| rx_en | input | 1 | Receive enable; gates loading of finished frames |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| rxd | input | 1 | Serial receive line, idle high |
| host_rd | input | 1 | One-cycle strobe: host has read `rx_data` |
| rx_data | output | 8 | Buffered received byte |
| rx_done_irq | output | 1 | One-cycle receive-complete interrupt pulse |

## Verification
The bound checker watches several properties on every cycle. It checks the forced all-ones value under unit disable, the one-cycle width of the interrupt, and that the interrupt comes with every change of the register. It also checks that no interrupt follows a disabled receiver, that no 7-bit load sets bit 7, and that no frame completing against a pending read raises an interrupt. Some behaviour appears only over a whole frame, and only the bench scenarios show it. These are LSB-first bit order and correct mid-bit sampling, rejection of a short glitch, retention of the old byte through a dropped or disabled frame, and the pending-read flag being cleared by a host read or by a unit disable.

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unit_en,
  input  logic       rx_en,
  input  logic       len7,
  input  logic       rxd,
  input  logic       host_rd,
  output logic [7:0] rx_data,
  output logic       rx_done_irq
);

  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [2:0]     bidx;
  logic [7:0]     shreg;
  logic           short_q;
  logic           rxd_m, rxd_s;
  logic           rd_pend;
  logic           frm_done, ovr, load;
  logic [2:0]     last_idx;

  assign last_idx = short_q ? 3'd6 : 3'd7;
  assign frm_done = (st == S_STOP) && (cnt == FULL_M1);
  assign ovr      = frm_done & rd_pend;
  assign load     = frm_done & rx_en & ~ovr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      short_q <= 1'b0;
    end else if (!unit_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rxd_s) begin
            st      <= S_START;
            short_q <= len7;
          end
        end
        S_START: begin
          if (cnt == HALF_M1) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        S_DATA: begin
          if (cnt == FULL_M1) begin
            cnt         <= '0;
            shreg[bidx] <= rxd_s;
            if (bidx == last_idx) st <= S_STOP;
            else                  bidx <= bidx + 3'd1;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        default: begin
          if (cnt == FULL_M1) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !unit_en) begin
      rx_data     <= 8'hFF;
      rx_done_irq <= 1'b0;
      rd_pend     <= 1'b0;
    end else begin
      rx_done_irq <= load;
      if (load) begin
        rx_data <= {shreg[7] & ~len7, shreg[6:0]};
        rd_pend <= 1'b1;
      end else if (host_rd) begin
        rd_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       unit_en,
  input logic       rx_en,
  input logic       len7,
  input logic [7:0] rx_data,
  input logic       rx_done_irq,
  input logic       frm_done,
  input logic       rd_pend
);

  p_disable_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (rx_data == 8'hFF) && !rx_done_irq);

  p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |=> !rx_done_irq);

  p_change_has_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_done_irq || (rx_data == 8'hFF));

  p_no_irq_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |-> $past(rx_en));

  p_msb_clear_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |-> !($past(len7) && rx_data[7]));

  p_overrun_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && rd_pend |=> !rx_done_irq);

endmodule

bind uart_rx_hold uart_rx_hold_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .unit_en    (unit_en),
  .rx_en      (rx_en),
  .len7       (len7),
  .rx_data    (rx_data),
  .rx_done_irq(rx_done_irq),
  .frm_done   (frm_done),
  .rd_pend    (rd_pend)
);

// File: tb/uart_rx_hold_test.sv
module uart_rx_hold_test;
  localparam int OVS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unit_en = 1'b1;
  logic rx_en = 1'b1;
  logic len7 = 1'b0;
  logic rxd = 1'b1;
  logic host_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_done_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  logic [7:0] irq_data = 8'h00;

  always #10 clk = ~clk;

  uart_rx_hold #(.OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .rx_en(rx_en),
    .len7(len7), .rxd(rxd), .host_rd(host_rd),
    .rx_data(rx_data), .rx_done_irq(rx_done_irq)
  );

  always @(negedge clk) begin
    if (rx_done_irq) begin
      irq_cnt  <= irq_cnt + 1;
      irq_data <= rx_data;
    end
  end

  // {len7, rx_en, read_before, sent_byte, expect_irq, expect_data}
  localparam logic [19:0] VEC [0:10] = '{
    {1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A},
    {1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h7F},
    {1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 8'h7F},
    {1'b0, 1'b1, 1'b0, 8'h22, 1'b1, 8'h22},
    {1'b0, 1'b1, 1'b0, 8'h33, 1'b0, 8'h22},
    {1'b0, 1'b1, 1'b1, 8'h80, 1'b1, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, 8'hFF},
    {1'b1, 1'b1, 1'b1, 8'h80, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic short7);
    rxd = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < (short7 ? 7 : 8); i++) begin
      rxd = b[i];
      repeat (OVS) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (OVS + 2) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int c0;
    string tag;
    repeat (3) @(negedge clk);
    chk("R1 reset data", rx_data, 8'hFF);
    chk("R1 reset irq", rx_done_irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset data", rx_data, 8'hFF);

    // Entry 5 loads with no read because entry 4 read; entry 7 reads after overrun (R8).
    for (int k = 0; k < 11; k++) begin
      logic [19:0] v;
      v = VEC[k];
      if (v[19])       tag = "R6";
      else if (!v[18]) tag = "R5";
      else if (!v[8])  tag = "R7";
      else if (k == 7) tag = "R8";
      else             tag = "R3";
      @(negedge clk);
      len7  = v[19];
      rx_en = v[18];
      if (v[17]) pulse_rd();
      c0 = irq_cnt;
      send(v[16:9], v[19]);
      chk({tag, " data"}, rx_data, v[7:0]);
      chk("R4 irq count", irq_cnt - c0, v[8] ? 1 : 0);
      if (v[8]) chk("R4 data with irq", irq_data, v[7:0]);
    end

    // R9: short glitch
    len7 = 1'b0;
    rx_en = 1'b1;
    pulse_rd();
    c0 = irq_cnt;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    chk("R9 glitch irq", irq_cnt - c0, 0);
    chk("R9 glitch data", rx_data, 8'h00);
    send(8'hC3, 1'b0);
    chk("R9 frame after glitch", rx_data, 8'hC3);
    chk("R9 irq after glitch", irq_cnt - c0, 1);

    // R2 / R10: disable with read pending
    @(negedge clk) unit_en = 1'b0;
    @(negedge clk);
    chk("R2 disabled data", rx_data, 8'hFF);
    chk("R2 disabled irq", rx_done_irq, 0);
    c0 = irq_cnt;
    send(8'h5A, 1'b0);
    chk("R2 frame while off irq", irq_cnt - c0, 0);
    chk("R2 frame while off data", rx_data, 8'hFF);
    @(negedge clk) unit_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 re-enable data", rx_data, 8'hFF);
    send(8'h69, 1'b0);
    chk("R10 load without read", rx_data, 8'h69);
    chk("R10 irq without read", irq_cnt - c0, 1);

    // R1: reset during operation
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset data", rx_data, 8'hFF);
    chk("R1 mid-run reset irq", rx_done_irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule